// File: doc/BRIEF.md
# Sampled Redundant Workgroup Checker

This block watches the stream of workgroups leaving the dispatcher and, at a programmable rate of one in N, marks a workgroup for shadow execution. A marked workgroup runs on its normal compute unit (the primary copy) and, at the same time, on a dedicated shadow compute unit. Every global store from the shadow unit is flagged for suppression, so the shadow copy never changes memory.

Both copies are tracked by the stores they retire to global memory. Each qualifying store is hashed from its address, wavefront tag and data, and the hash is added into a per-copy signature. The sum does not depend on the order in which stores arrive, so wavefronts may retire in any interleaving. Once both copies report completion, the two signatures are compared. A difference raises a sticky fault flag and records the workgroup ID of the first mismatch. The flag stays set until it is cleared.

Only one shadowed workgroup can be in flight at a time. A controller with three states handles this:

- `ST_IDLE` moves to `ST_RUN` on transition START, when a dispatch is duplicated.
- `ST_RUN` moves to `ST_CMP` on transition BOTH_DONE, when both completions have been seen.
- `ST_CMP` moves to `ST_IDLE` on transition RETIRE, after a single comparison cycle.

Top module: `wg_shadow_checker`

## Requirements
- R1: After reset `busy`, `fault`, `fault_wg`, `disp_dup` and `mb_suppress` are all 0, and the controller is in `ST_IDLE`.
- R2: With `cfg_period` = N ≥ 1, an internal count of dispatches (cycles with `disp_valid`) makes every Nth dispatch *due*, and the count restarts after each due dispatch. With `cfg_period` = 0 no dispatch is ever due, and the count stays at zero.
- R3: A due dispatch that arrives while `busy` is 1 is not duplicated. It is skipped, not deferred, and the count still restarts.
- R4: `disp_dup` is high in the same cycle as a due dispatch taken in `ST_IDLE`. `busy` is 1 from the next cycle on (START).
- R5: `mb_suppress` is high, combinationally, whenever `mb_valid` and `mb_global` are 1 and `mb_cu` equals the shadow unit ID `SHADOW_CU` (default 15). This holds whether or not a sample is in flight.
- R6: During `ST_RUN`, a primary-copy store counts only if:
  - it is valid and global,
  - `ma_cu` equals the captured dispatch unit,
  - `ma_wg` equals the captured workgroup.

  A shadow-copy store counts under the same conditions, except that its unit must be `SHADOW_CU`. Each counted store adds h = ((addr ^ wf) * 0x9E3779B1) ^ data, modulo 2^32, into its copy's signature. Both signatures are zeroed at START.
- R7: The signatures are compared only after both copies have completed. Completion is a `fa_valid`/`fb_valid` pulse carrying the matching unit and workgroup. `busy` falls, and `fault` updates, at the second clock edge after the edge that samples the later completion (BOTH_DONE, then RETIRE).
- R8: A signature mismatch sets `fault` and loads the captured workgroup ID into `fault_wg`. While `fault` is set, later mismatches change neither output.
- R9: Matching signatures leave `fault` unchanged. A cycle with `fault_clr` clears `fault` and `fault_wg` to 0.
- R10: The result does not depend on the order in which each copy retires its stores.
- R11: The signatures ignore stores that are non-global, carry another workgroup or unit, or arrive outside `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | 8 | Sampling period N (0 disables sampling) |
| fault_clr | input | 1 | Clears the sticky fault and recorded ID |
| disp_valid | input | 1 | A workgroup is dispatched this cycle |
| disp_cu | input | 4 | Compute unit the workgroup is sent to |
| disp_wg | input | 8 | Workgroup ID of the dispatch |
| disp_dup | output | 1 | Duplicate this dispatch onto the shadow unit |
| ma_valid | input | 1 | Primary-side store retire valid |
| ma_global | input | 1 | Primary-side store targets global memory |
| ma_cu | input | 4 | Primary-side store unit tag |
| ma_wg | input | 8 | Primary-side store workgroup tag |
| ma_wf | input | 4 | Primary-side store wavefront tag |
| ma_addr | input | 32 | Primary-side store address |
| ma_data | input | 32 | Primary-side store data |
| mb_valid | input | 1 | Shadow-side store retire valid |
| mb_global | input | 1 | Shadow-side store targets global memory |
| mb_cu | input | 4 | Shadow-side store unit tag |
| mb_wg | input | 8 | Shadow-side store workgroup tag |
| mb_wf | input | 4 | Shadow-side store wavefront tag |
| mb_addr | input | 32 | Shadow-side store address |
| mb_data | input | 32 | Shadow-side store data |
| mb_suppress | output | 1 | Block this shadow-side global write |
| fa_valid | input | 1 | Primary-side workgroup completion |
| fa_cu | input | 4 | Unit reporting primary completion |
| fa_wg | input | 8 | Workgroup reporting primary completion |
| fb_valid | input | 1 | Shadow-side workgroup completion |
| fb_cu | input | 4 | Unit reporting shadow completion |
| fb_wg | input | 8 | Workgroup reporting shadow completion |
| busy | output | 1 | A shadowed workgroup is in flight |
| fault | output | 1 | Sticky signature-mismatch flag |
| fault_wg | output | 8 | Workgroup ID of the first mismatch |

## Verification
The assertions take for granted several things about the inputs:

- `cfg_period` stays constant between dispatches when spacing is checked.
- `fault_clr` is not pulsed in the cycle of a comparison.
- Each copy reports completion once per shadowed workgroup.

The stimulus follows these rules. It changes the period only while no dispatch is pending, it pulses the clear only when the controller is idle, and it issues exactly one completion per copy. Random store sets are drawn from a fixed seed. The shadow copy replays them in reverse order, and a corruption, when injected, flips one data bit.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CMP  = 2'd2
    } wgc_state_e;

    localparam logic [31:0] MIX_K = 32'h9E37_79B1;
endpackage

// File: rtl/wgc_sampler.sv
module wgc_sampler #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             disp_valid,
    output logic             due
);
    logic [PER_W-1:0] cnt;

    always_comb begin
        due = disp_valid && (cfg_period != '0) &&
              (cnt >= (cfg_period - PER_W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (disp_valid) begin
            if (cfg_period == '0 || due) cnt <= '0;
            else                         cnt <= cnt + PER_W'(1);
        end
    end

    // R2: with a steady period above one, two due dispatches never follow back to back
    a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (due && cfg_period > PER_W'(1)) |=> !(due && $stable(cfg_period)));
endmodule

// File: rtl/wgc_sig_accum.sv
module wgc_sig_accum #(
    parameter int CU_W   = 4,
    parameter int WG_W   = 8,
    parameter int WF_W   = 4,
    parameter int ADDR_W = 32,
    parameter int SUM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic [CU_W-1:0]   want_cu,
    input  logic [WG_W-1:0]   want_wg,
    input  logic              st_valid,
    input  logic              st_global,
    input  logic [CU_W-1:0]   st_cu,
    input  logic [WG_W-1:0]   st_wg,
    input  logic [WF_W-1:0]   st_wf,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SUM_W-1:0]  st_data,
    output logic [SUM_W-1:0]  sum
);
    logic             hit;
    logic [SUM_W-1:0] mix;

    always_comb begin
        hit = active && st_valid && st_global &&
              (st_cu == want_cu) && (st_wg == want_wg);
        mix = ((SUM_W'(st_addr) ^ SUM_W'(st_wf)) * SUM_W'(wgc_pkg::MIX_K)) ^ st_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (hit) sum <= sum + mix;
    end

    // R6: a start zeroes the signature
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0));
    // R11: without a qualifying store the signature holds
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(st_valid && st_global && active)) |=> $stable(sum));
endmodule

// File: rtl/wg_shadow_checker.sv
module wg_shadow_checker #(
    parameter int                 PER_W     = 8,
    parameter int                 CU_W      = 4,
    parameter int                 WG_W      = 8,
    parameter int                 WF_W      = 4,
    parameter int                 ADDR_W    = 32,
    parameter int                 DATA_W    = 32,
    parameter logic [CU_W-1:0]    SHADOW_CU = 4'd15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              fault_clr,
    input  logic              disp_valid,
    input  logic [CU_W-1:0]   disp_cu,
    input  logic [WG_W-1:0]   disp_wg,
    output logic              disp_dup,
    input  logic              ma_valid,
    input  logic              ma_global,
    input  logic [CU_W-1:0]   ma_cu,
    input  logic [WG_W-1:0]   ma_wg,
    input  logic [WF_W-1:0]   ma_wf,
    input  logic [ADDR_W-1:0] ma_addr,
    input  logic [DATA_W-1:0] ma_data,
    input  logic              mb_valid,
    input  logic              mb_global,
    input  logic [CU_W-1:0]   mb_cu,
    input  logic [WG_W-1:0]   mb_wg,
    input  logic [WF_W-1:0]   mb_wf,
    input  logic [ADDR_W-1:0] mb_addr,
    input  logic [DATA_W-1:0] mb_data,
    output logic              mb_suppress,
    input  logic              fa_valid,
    input  logic [CU_W-1:0]   fa_cu,
    input  logic [WG_W-1:0]   fa_wg,
    input  logic              fb_valid,
    input  logic [CU_W-1:0]   fb_cu,
    input  logic [WG_W-1:0]   fb_wg,
    output logic              busy,
    output logic              fault,
    output logic [WG_W-1:0]   fault_wg
);
    import wgc_pkg::*;

    localparam int SUM_W = DATA_W;

    wgc_state_e        state, state_nx;
    logic              due, run;
    logic [CU_W-1:0]   cap_cu;
    logic [WG_W-1:0]   cap_wg;
    logic              done_a, done_b;
    logic [SUM_W-1:0]  sig_a, sig_b;
    logic              fin_a_hit, fin_b_hit;

    wgc_sampler #(.PER_W(PER_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .disp_valid(disp_valid), .due(due)
    );

    wgc_sig_accum #(.CU_W(CU_W), .WG_W(WG_W), .WF_W(WF_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_sig_a (
        .clk(clk), .rst_n(rst_n), .clr(disp_dup), .active(run),
        .want_cu(cap_cu), .want_wg(cap_wg),
        .st_valid(ma_valid), .st_global(ma_global), .st_cu(ma_cu), .st_wg(ma_wg),
        .st_wf(ma_wf), .st_addr(ma_addr), .st_data(ma_data), .sum(sig_a)
    );

    wgc_sig_accum #(.CU_W(CU_W), .WG_W(WG_W), .WF_W(WF_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_sig_b (
        .clk(clk), .rst_n(rst_n), .clr(disp_dup), .active(run),
        .want_cu(SHADOW_CU), .want_wg(cap_wg),
        .st_valid(mb_valid), .st_global(mb_global), .st_cu(mb_cu), .st_wg(mb_wg),
        .st_wf(mb_wf), .st_addr(mb_addr), .st_data(mb_data), .sum(sig_b)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state: START, BOTH_DONE, RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (disp_dup)         state_nx = ST_RUN;
            ST_RUN:  if (done_a && done_b) state_nx = ST_CMP;
            ST_CMP:                        state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run         = (state == ST_RUN);
        busy        = (state != ST_IDLE);
        disp_dup    = due && (state == ST_IDLE);
        mb_suppress = mb_valid && mb_global && (mb_cu == SHADOW_CU);
        fin_a_hit   = fa_valid && (fa_cu == cap_cu) && (fa_wg == cap_wg);
        fin_b_hit   = fb_valid && (fb_cu == SHADOW_CU) && (fb_wg == cap_wg);
    end

    // capture, completion tracking and sticky fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_cu   <= '0;
            cap_wg   <= '0;
            done_a   <= 1'b0;
            done_b   <= 1'b0;
            fault    <= 1'b0;
            fault_wg <= '0;
        end else begin
            if (disp_dup) begin
                cap_cu <= disp_cu;
                cap_wg <= disp_wg;
                done_a <= 1'b0;
                done_b <= 1'b0;
            end
            if (run && fin_a_hit) done_a <= 1'b1;
            if (run && fin_b_hit) done_b <= 1'b1;
            if (fault_clr) begin
                fault    <= 1'b0;
                fault_wg <= '0;
            end
            if (state == ST_CMP && sig_a != sig_b && (!fault || fault_clr)) begin
                fault    <= 1'b1;
                fault_wg <= cap_wg;
            end
        end
    end

    // R4: a duplicated dispatch leaves a sample in flight
    a_r4_busy_after_dup: assert property (@(posedge clk) disable iff (!rst_n)
        disp_dup |=> busy);
    // R7: the compare state lasts exactly one cycle
    a_r7_single_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP) |=> (state == ST_IDLE));
    // R8: fault stays set without a clear
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);
    // R8: recorded ID is held while the fault stands
    a_r8_wg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> $stable(fault_wg));
    // R9: a clear with no comparison pending drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && state != ST_CMP) |=> !fault);
endmodule

// File: tb/wg_shadow_checker_tb_top.sv
`timescale 1ns/1ps
module wg_shadow_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_period = '0;
    logic        fault_clr = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_cu = '0;
    logic [7:0]  disp_wg = '0;
    logic        disp_dup;
    logic        ma_valid = 1'b0, ma_global = 1'b0;
    logic [3:0]  ma_cu = '0, ma_wf = '0;
    logic [7:0]  ma_wg = '0;
    logic [31:0] ma_addr = '0, ma_data = '0;
    logic        mb_valid = 1'b0, mb_global = 1'b0;
    logic [3:0]  mb_cu = '0, mb_wf = '0;
    logic [7:0]  mb_wg = '0;
    logic [31:0] mb_addr = '0, mb_data = '0;
    logic        mb_suppress;
    logic        fa_valid = 1'b0, fb_valid = 1'b0;
    logic [3:0]  fa_cu = '0, fb_cu = '0;
    logic [7:0]  fa_wg = '0, fb_wg = '0;
    logic        busy, fault;
    logic [7:0]  fault_wg;

    localparam logic [3:0] SHD = 4'd15;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // model state
    int m_cnt = 0;
    bit m_busy = 0;
    bit m_fault = 0;
    logic [7:0] m_fwg = '0;

    logic [31:0] sa [8];
    logic [31:0] sd [8];
    logic [3:0]  sw [8];

    always #2 clk = ~clk;

    wg_shadow_checker dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hmix(input logic [31:0] a, input logic [3:0] w, input logic [31:0] d);
        return ((a ^ {28'd0, w}) * 32'h9E37_79B1) ^ d;
    endfunction

    function automatic logic [31:0] sig_of(input int n, input bit flip);
        logic [31:0] s = '0;
        for (int i = 0; i < n; i++)
            s += hmix(sa[i], sw[i], (i == 0 && flip) ? (sd[i] ^ 32'h10) : sd[i]);
        return s;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        disp_valid = 0; ma_valid = 0; mb_valid = 0;
        fa_valid = 0; fb_valid = 0; fault_clr = 0;
    endtask

    task automatic dispatch(input logic [7:0] wg, input logic [3:0] cu, input string req);
        bit due, exp_dup;
        @(negedge clk);
        disp_valid = 1; disp_wg = wg; disp_cu = cu;
        due = (cfg_period != 0) && (m_cnt >= int'(cfg_period) - 1);
        exp_dup = due && !m_busy;
        if (cfg_period == 0 || due) m_cnt = 0; else m_cnt++;
        #1 chk(disp_dup == exp_dup, req, disp_dup, exp_dup);
        if (exp_dup) m_busy = 1;
        tick();
        if (exp_dup) chk(busy == 1'b1, "R4", busy, 1);
    endtask

    task automatic store(input bit av, input logic [3:0] acu, input logic [7:0] awg, input bit ag,
                         input logic [31:0] aa, input logic [3:0] aw, input logic [31:0] ad,
                         input bit bv, input logic [3:0] bcu, input logic [7:0] bwg, input bit bg,
                         input logic [31:0] ba, input logic [3:0] bw, input logic [31:0] bd);
        bit es;
        @(negedge clk);
        ma_valid = av; ma_cu = acu; ma_wg = awg; ma_global = ag; ma_addr = aa; ma_wf = aw; ma_data = ad;
        mb_valid = bv; mb_cu = bcu; mb_wg = bwg; mb_global = bg; mb_addr = ba; mb_wf = bw; mb_data = bd;
        es = bv && bg && (bcu == SHD);
        #1 chk(mb_suppress == es, "R5", mb_suppress, es);
        tick();
    endtask

    // completes both copies, checks timing and fault outcome
    task automatic finish_both(input logic [7:0] wg, input logic [3:0] cu, input bit mism);
        @(negedge clk);
        fa_valid = 1; fa_cu = cu; fa_wg = wg;
        tick();
        @(negedge clk);
        fb_valid = 1; fb_cu = SHD; fb_wg = wg;
        tick();
        @(posedge clk); #1;
        chk(busy == 1'b1, "R7 compare pending", busy, 1);
        @(posedge clk); #1;
        chk(busy == 1'b0, "R7 retire", busy, 0);
        m_busy = 0;
        if (mism && !m_fault) begin m_fault = 1; m_fwg = wg; end
        chk(fault == m_fault, "R8/R9 fault", fault, m_fault);
        chk(fault_wg == m_fwg, "R8 fault_wg", fault_wg, m_fwg);
    endtask

    task automatic clear_fault();
        @(negedge clk);
        fault_clr = 1;
        tick();
        m_fault = 0; m_fwg = '0;
        chk(fault == 1'b0 && fault_wg == 8'd0, "R9 clear", {fault, fault_wg}, 0);
    endtask

    // one sampled workgroup with n random stores; shadow replays them reversed (R10)
    task automatic sample_run(input logic [7:0] wg, input logic [3:0] cu, input int n, input bit flip);
        logic [31:0] ga, gb;
        for (int i = 0; i < n; i++) begin
            sa[i] = $urandom; sd[i] = $urandom; sw[i] = 4'($urandom);
        end
        for (int i = 0; i < n; i++) begin
            int j = n - 1 - i;
            store(1, cu, wg, 1, sa[i], sw[i], sd[i],
                  1, SHD, wg, 1, sa[j], sw[j], (j == 0 && flip) ? (sd[j] ^ 32'h10) : sd[j]);
        end
        ga = sig_of(n, 0);
        gb = sig_of(n, flip);
        finish_both(wg, cu, ga != gb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #7 rst_n = 1;
        #1;
        chk(busy == 0 && fault == 0 && fault_wg == 0 && disp_dup == 0 && mb_suppress == 0,
            "R1 reset", {busy, fault, fault_wg}, 0);

        // R5 suppress while idle
        store(0, 0, 0, 0, 0, 0, 0, 1, SHD, 8'd77, 1, 32'h100, 0, 32'h5);

        // R2 / R3 with period 3
        cfg_period = 8'd3;
        for (int i = 0; i < 3; i++) dispatch(8'(i + 20), 4'd2, "R2 one-in-three");
        for (int i = 0; i < 3; i++) dispatch(8'(i + 30), 4'd3, "R3 skip while busy");

        // matching run with noise stores (R6 R10 R11)
        for (int i = 0; i < 4; i++) begin
            sa[i] = $urandom; sd[i] = $urandom; sw[i] = 4'(i);
        end
        store(1, 4'd2, 8'd22, 1, sa[0], sw[0], sd[0], 1, SHD, 8'd22, 1, sa[3], sw[3], sd[3]);
        store(1, 4'd2, 8'd99, 1, 32'hDEAD, 0, 32'hBEEF, 1, 4'd7, 8'd22, 1, 32'hDEAD, 0, 32'h1);  // R11 wrong tags
        store(1, 4'd2, 8'd22, 0, 32'hAAAA, 0, 32'h2, 1, SHD, 8'd22, 0, 32'hBBBB, 0, 32'h3);       // R11 non-global
        store(1, 4'd2, 8'd22, 1, sa[1], sw[1], sd[1], 1, SHD, 8'd22, 1, sa[2], sw[2], sd[2]);
        store(1, 4'd2, 8'd22, 1, sa[2], sw[2], sd[2], 1, SHD, 8'd22, 1, sa[1], sw[1], sd[1]);
        store(1, 4'd2, 8'd22, 1, sa[3], sw[3], sd[3], 1, SHD, 8'd22, 1, sa[0], sw[0], sd[0]);
        finish_both(8'd22, 4'd2, sig_of(4, 0) != sig_of(4, 0));

        // R8 mismatch with period 1
        cfg_period = 8'd1; m_cnt = 0;
        dispatch(8'd9, 4'd1, "R2 every dispatch");
        sample_run(8'd9, 4'd1, 3, 1);
        dispatch(8'd12, 4'd4, "R2 every dispatch");
        sample_run(8'd12, 4'd4, 2, 1);   // R8 first ID kept
        clear_fault();

        // R11: store outside ST_RUN then a clean run
        store(1, 4'd5, 8'd40, 1, 32'h1, 0, 32'h9, 0, 0, 0, 0, 0, 0, 0);
        dispatch(8'd40, 4'd5, "R2");
        sample_run(8'd40, 4'd5, 2, 0);

        // R2 period zero disables
        cfg_period = 8'd0;
        for (int i = 0; i < 4; i++) dispatch(8'(i + 50), 4'd0, "R2 disabled");

        // random runs
        cfg_period = 8'd1; m_cnt = 0;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] wg = 8'($urandom);
            logic [3:0] cu = 4'($urandom_range(0, 14));
            dispatch(wg, cu, "R4 random");
            sample_run(wg, cu, 1 + int'($urandom_range(0, 7)), 1'($urandom));
            if (m_fault) clear_fault();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule